// File: doc/BRIEF.md
# MDIO Management Cycle Master

This block lets software talk to an external Ethernet PHY over the two-wire management interface. Software programs a control register with the target PHY number, the register index inside that PHY, a direction flag and a divider code, and sets the busy flag to launch the cycle. A separate 16-bit data register supplies the value to send on a write, and it receives the value that the PHY returns on a read.

While a cycle runs, the block divides the system clock down to the management clock (MDC). It then shifts out a 64-bit frame, most significant bit first. The frame begins with a 32-bit all-ones preamble. Next come a start pattern, an opcode, the two 5-bit addresses and a two-bit turnaround, and the frame ends with 16 data bits. The serial data pin is split into an output value, an output enable and an input. When the frame completes, hardware clears the busy flag, and software polls that flag to learn that the cycle has finished.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control register and the data register both read zero, MDC is low and the MDIO output enable is low.
- R2: A write to the control register (reg_sel=0) stores the PHY number from bits 15:11, the register index from bits 10:6, the divider code from bits 4:2, the direction from bit 1 and busy from bit 0. Reading it back places those fields at the same positions, and bits 31:16 and bit 5 read zero. A write to the data register (reg_sel=1) stores bits 15:0.
- R3: The divider code selects the MDC period in system clocks: 3'b000 gives 42, 3'b010 gives 16 and 3'b011 gives 26. Within each period, MDC is low for the first half and high for the second half.
- R4: Any other divider code (3'b001 or 3'b100 to 3'b111) gives the 42-clock period.
- R5: Writing busy=1 while idle starts a frame on the next clock. The frame is 64 bits, MSB first, one bit per MDC period: 32 ones, start 0 then 1, opcode 0,1 for a write (bit 1 = 1) or 1,0 for a read, then the PHY number, the register index, two turnaround bits and 16 data bits.
- R6: On a write, the turnaround is driven as 1 then 0, the 16 data bits come from the data register, and the output enable stays high for the whole frame.
- R7: On a read, the output enable drops for the turnaround and the data bits (frame bits 46 to 63). MDIO is sampled while MDC is high in each data bit, and at the end of the frame the 16 sampled bits (first sampled = MSB) are placed in the data register.
- R8: Busy reads 1 during the 64 MDC periods of the frame and reads 0 on the first clock after the last period ends.
- R9: While busy reads 1, writes to the control register and to the data register have no effect on either register or on the frame in progress.
- R10: Whenever no frame is running, MDC is held low and MDIO is released (output enable low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the data register |
| reg_wdata | input | 32 | Register write value |
| ctrl_rdata | output | 32 | Control register readback |
| data_rdata | output | 16 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data value driven to the pin |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_in | input | 1 | Serial data value seen on the pin |

## Verification
The bench targets the three real divisors and two reserved codes. A decoder that passes reserved codes through, or that inverts the high and low halves of MDC, shows up within a single MDC period in the per-clock comparison. Read frames test where the enable is released and which bits are sampled. Releasing one bit late shows as a mismatch on the enable at frame bit 46, and an off-by-one sample leaves a shifted value in the data register. Writes made in the middle of a frame test the busy lock: a design that accepts them corrupts the readback fields, changes the data sent, or restarts the bit sequence. Checks on the busy flag on both sides of the final MDC period catch a flag that clears one period early or late.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;
    localparam int DATA_POS  = TA_POS + 2;
    localparam int BIT_W     = $clog2(FRAME_LEN);
    localparam int CNT_W     = 6;
    localparam int CR_W      = 3;

    localparam logic [CR_W-1:0] CR_DIV16 = 3'b010;
    localparam logic [CR_W-1:0] CR_DIV26 = 3'b011;

    function automatic logic [CNT_W-1:0] cr_to_div(input logic [CR_W-1:0] code);
        case (code)
            CR_DIV16: cr_to_div = CNT_W'(16);
            CR_DIV26: cr_to_div = CNT_W'(26);
            default:  cr_to_div = CNT_W'(42);
        endcase
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
    import mdio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            run,
    input  logic [CR_W-1:0] cr_code,
    output logic            mdc,
    output logic            rise,
    output logic            bit_end
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] div;
    } div_state_t;

    div_state_t q, d;
    logic [CNT_W-1:0] half;

    assign half = q.div >> 1;

    always_comb begin
        d = q;
        if (start) begin
            d.cnt = '0;
            d.div = cr_to_div(cr_code);
        end else if (run) begin
            d.cnt = (q.cnt == q.div - 1'b1) ? '0 : q.cnt + 1'b1;
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.div <= CNT_W'(42);
        end else begin
            q <= d;
        end
    end

    assign mdc     = run && (q.cnt >= half);
    assign rise    = run && (q.cnt == half);
    assign bit_end = run && (q.cnt == q.div - 1'b1);

    a_r4_div_legal: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (q.div == 6'd16 || q.div == 6'd26 || q.div == 6'd42));
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> q.cnt < q.div);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              is_write,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              bit_end,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [FRAME_LEN-1:0] sh;
        logic [BIT_W-1:0]     bitn;
        logic                 wr;
        logic [DATA_W-1:0]    rx;
    } seq_state_t;

    seq_state_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.sh   = {{PRE_LEN{1'b1}}, 2'b01, (is_write ? 2'b01 : 2'b10),
                      phy_addr, reg_addr, 2'b10, (is_write ? wdata : {DATA_W{1'b0}})};
            d.bitn = '0;
            d.wr   = is_write;
            d.rx   = '0;
        end else if (run) begin
            if (rise && !q.wr && q.bitn >= BIT_W'(DATA_POS))
                d.rx = {q.rx[DATA_W-2:0], mdio_in};
            if (bit_end) begin
                d.sh   = q.sh << 1;
                d.bitn = q.bitn + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdio_oe  = run && (q.wr || q.bitn < BIT_W'(TA_POS));
    assign mdio_out = mdio_oe && q.sh[FRAME_LEN-1];
    assign done     = bit_end && (q.bitn == BIT_W'(FRAME_LEN - 1));
    assign rdata    = q.rx;

    a_r5_start_at_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.bitn == '0 && q.sh[FRAME_LEN-1]));
    a_r7_no_capture_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.wr && !start) |=> $stable(q.rx));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] ctrl_rdata,
    output logic [15:0] data_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regi;
        logic [CR_W-1:0]   cr;
        logic              wr;
        logic              busy;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t q, d;
    logic start, rise, bit_end, done;
    logic [DATA_W-1:0] rdata;
    logic unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:16], reg_wdata[5]};
    assign start = reg_wr && !reg_sel && reg_wdata[0] && !q.busy;

    always_comb begin
        d = q;
        if (reg_wr && !q.busy) begin
            if (!reg_sel) begin
                d.phy  = reg_wdata[15:11];
                d.regi = reg_wdata[10:6];
                d.cr   = reg_wdata[4:2];
                d.wr   = reg_wdata[1];
                d.busy = reg_wdata[0];
            end else begin
                d.data = reg_wdata[DATA_W-1:0];
            end
        end
        if (done) begin
            d.busy = 1'b0;
            if (!q.wr) d.data = rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl_rdata = {16'h0000, q.phy, q.regi, 1'b0, q.cr, q.wr, q.busy};
    assign data_rdata = q.data;

    mdio_clk_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (q.busy),
        .cr_code (reg_wdata[4:2]),
        .mdc     (mdc),
        .rise    (rise),
        .bit_end (bit_end)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .run      (q.busy),
        .phy_addr (reg_wdata[15:11]),
        .reg_addr (reg_wdata[10:6]),
        .is_write (reg_wdata[1]),
        .wdata    (q.data),
        .rise     (rise),
        .bit_end  (bit_end),
        .mdio_in  (mdio_in),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rdata    (rdata)
    );

    a_r8_busy_clears_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(done));
    a_r9_fields_locked: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> $stable({q.phy, q.regi, q.cr, q.wr}));
    a_r9_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !done) |=> $stable(q.data));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> (!mdio_oe && !mdc));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic [15:0] data_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_div(input logic [2:0] cr);
        if (cr == 3'b010) return 16;       // R3
        else if (cr == 3'b011) return 26;  // R3
        else return 42;                    // R3 code 000, R4 reserved codes
    endfunction

    task automatic wr_reg(input logic sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [2:0] cr,
                             input logic mw, input logic [15:0] wd, input logic [15:0] phy_rd,
                             input bit inject);
        bit fb[$];
        int n;
        int b;
        int c;
        logic [3:0] exp_v;
        logic [3:0] act_v;
        logic exp_oe;
        n = exp_div(cr);
        if (mw) wr_reg(1'b1, {16'h0, wd});
        repeat (32) fb.push_back(1'b1);
        fb.push_back(1'b0); fb.push_back(1'b1);
        fb.push_back(!mw); fb.push_back(mw);
        for (int i = 4; i >= 0; i--) fb.push_back(phy[i]);
        for (int i = 4; i >= 0; i--) fb.push_back(ra[i]);
        fb.push_back(1'b1); fb.push_back(1'b0);
        for (int i = 15; i >= 0; i--) fb.push_back(mw ? wd[i] : 1'b0);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0;
        reg_wdata = {16'h0, phy, ra, 1'b0, cr, mw, 1'b1};
        for (int k = 0; k < 64 * n; k++) begin
            @(negedge clk);
            reg_wr = 1'b0;
            b = k / n;
            c = k % n;
            exp_oe = mw || (b < 46);
            exp_v = {(c >= n / 2), exp_oe, exp_oe & fb[b], 1'b1};
            act_v = {mdc, mdio_oe, mdio_oe & mdio_out, ctrl_rdata[0]};
            check(act_v == exp_v, "R3/R4/R5/R6/R7/R8/R9 per-clock frame", {28'h0, act_v}, {28'h0, exp_v});
            mdio_in = (!mw && b >= 48) ? phy_rd[15 - (b - 48)] : 1'b1;
            if (inject && k == 300) begin
                reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_FFFF;
            end
            if (inject && k == 400) begin
                reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0000_BEEF;
            end
        end
        mdio_in = 1'b1;
        @(negedge clk);
        check(ctrl_rdata[0] == 1'b0, "R8 busy cleared", ctrl_rdata, {31'h0, 1'b0});
        check(ctrl_rdata == {16'h0, phy, ra, 1'b0, cr, mw, 1'b0}, "R9 control fields kept",
              ctrl_rdata, {16'h0, phy, ra, 1'b0, cr, mw, 1'b0});
        check(data_rdata == (mw ? wd : phy_rd), "R7/R9 data register after frame",
              {16'h0, data_rdata}, {16'h0, (mw ? wd : phy_rd)});
        check(!mdc && !mdio_oe, "R10 idle after frame", {30'h0, mdc, mdio_oe}, 32'h0);
        repeat (5) @(negedge clk);
        check(!mdc && !mdio_oe, "R10 idle stays quiet", {30'h0, mdc, mdio_oe}, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ctrl_rdata == 32'h0, "R1 control reset", ctrl_rdata, 32'h0);
        check(data_rdata == 16'h0, "R1 data reset", {16'h0, data_rdata}, 32'h0);
        check(!mdc && !mdio_oe, "R1 pins reset", {30'h0, mdc, mdio_oe}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!mdc && !mdio_oe, "R10 idle after reset", {30'h0, mdc, mdio_oe}, 32'h0);
        wr_reg(1'b0, 32'hFFFF_FFFE);
        check(ctrl_rdata == 32'h0000_FFDE, "R2 field readback", ctrl_rdata, 32'h0000_FFDE);
        wr_reg(1'b1, 32'hFFFF_1357);
        check(data_rdata == 16'h1357, "R2 data write", {16'h0, data_rdata}, 32'h0000_1357);
        run_frame(5'h01, 5'h02, 3'b000, 1'b1, 16'hA5C3, 16'h0000, 1'b0);
        run_frame(5'h1F, 5'h00, 3'b010, 1'b0, 16'h0000, 16'h1234, 1'b0);
        run_frame(5'h0A, 5'h1F, 3'b011, 1'b1, 16'h8001, 16'h0000, 1'b1);
        run_frame(5'h15, 5'h0B, 3'b101, 1'b0, 16'h0000, 16'hFFFE, 1'b1);
        run_frame(5'h00, 5'h11, 3'b001, 1'b1, 16'h7E01, 16'h0000, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule